// File: doc/BRIEF.md
# Interleaved Reed-Solomon Frame Encoder

This block builds one 120-bit line frame per frame-clock cycle, which at the 40 MHz frame rate is one frame every 25 ns. Each frame carries an 80-bit user data word, a 2-bit link-control field, a 2-bit slow-control field and a 4-bit synchronisation header. Together these make 88 information bits, or 22 four-bit symbols. The header tells a receiver where a frame starts, and its value marks the frame as carrying data or as idle.

The information symbols are dealt alternately to two Reed-Solomon RS(15,11) codewords over GF(16). Each codeword gets four parity symbols. The two codewords are then merged symbol by symbol into the frame. Because of this interleave, a burst of up to four damaged symbols (16 bits) in one frame is still correctable downstream. The code efficiency is 88/120.

The encoder is purely combinational from the input ports to a single output register. Scrambling and serialisation follow it in the transmit chain.

Top module: `rsf_frame_enc`

## Requirements
- R1: `frame_o` is registered: after each rising edge of `clk` it holds the frame built from the inputs sampled at that edge, and it does not change between edges.
- R2: Driving `rst_n` low clears `frame_o` to all zeros at once, without waiting for a clock edge.
- R3: The header nibble `frame_o[119:116]` is 4'b0101 when `valid_i` was 1 and 4'b0110 when `valid_i` was 0.
- R4: `frame_o[119:32]` equals the concatenation {header, `lc_i`, `sc_i`, `data_i`}, sent in the clear. Information symbol k (k = 0..21) is bits [87-4k -: 4] of that 88-bit field.
- R5: The frame has 30 symbols, and symbol j sits at `frame_o[119-4j -: 4]`. Even j belongs to codeword A at position j/2. Odd j belongs to codeword B at position (j-1)/2. So codeword A parity sits at j = 22, 24, 26, 28 and codeword B parity at j = 23, 25, 27, 29.
- R6: Each codeword is systematic RS(15,11) over GF(16) with primitive polynomial x^4+x+1 and alpha = 4'h2. The polynomial is c(x) = sum of s_i·x^(14-i), where s_0 is the first symbol. The parity s_11..s_14 is the remainder of m(x)·x^4 divided by g(x) = x^4 + 4'hD·x^3 + 4'hC·x^2 + 4'h8·x + 4'h7, whose roots are alpha^1..alpha^4.
- R7: Every output frame decodes to two codewords whose four syndromes c(alpha^1)..c(alpha^4) are all zero.
- R8: No state carries between frames: while the inputs are held constant, `frame_o` stays constant from one frame to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Frame clock, one frame per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_i | input | 80 | User data word |
| lc_i | input | 2 | Link-control field |
| sc_i | input | 2 | Slow-control field |
| valid_i | input | 1 | 1 selects the data header code, 0 the idle header code |
| frame_o | output | 120 | Coded line frame |

## Verification
The only state in the block is the output register, so any fault in the parity network, the symbol dealing or the generator coefficients shows up in `frame_o` one edge after the input that exposes it. That faulty frame either differs from the bench's long-division reference or has a nonzero syndrome in one of the two codewords. A fault in the header multiplexer or in the payload order breaks the clear-text field of the same frame. Either way the fault cannot stay hidden, because the next frame recomputes everything from scratch.

// File: rtl/rsf_pkg.sv
package rsf_pkg;

   localparam int unsigned SYM_W     = 4;
   localparam logic [4:0]  PRIM_POLY = 5'h13;
   localparam int unsigned MAX_PAR   = 8;

   typedef logic [SYM_W-1:0] sym_t;

   // multiply by alpha, reduce modulo the primitive polynomial
   function automatic sym_t xtime(sym_t a);
      logic [SYM_W:0] t;
      t = {a, 1'b0};
      if (t[SYM_W]) t = t ^ PRIM_POLY[SYM_W:0];
      return t[SYM_W-1:0];
   endfunction

   function automatic sym_t gf_mul(sym_t a, sym_t b);
      sym_t acc;
      sym_t sh;
      acc = '0;
      sh  = a;
      for (int i = 0; i < SYM_W; i++) begin
         if (b[i]) acc = acc ^ sh;
         sh = xtime(sh);
      end
      return acc;
   endfunction

   // coefficient of x^idx in prod_{j=1..npar} (x + alpha^j)
   function automatic sym_t gen_coef(int npar, int idx);
      sym_t c [0:MAX_PAR];
      sym_t root;
      for (int i = 0; i <= MAX_PAR; i++) c[i] = '0;
      c[0] = sym_t'(1);
      root = sym_t'(1);
      for (int j = 1; j <= npar; j++) begin
         root = xtime(root);
         for (int i = MAX_PAR; i >= 1; i--) c[i] = c[i-1] ^ gf_mul(root, c[i]);
         c[0] = gf_mul(root, c[0]);
      end
      return c[idx];
   endfunction

endpackage

// File: rtl/rsf_lane_split.sv
module rsf_lane_split
   import rsf_pkg::*;
#(
   parameter int unsigned DEPTH = 2,
   parameter int unsigned K     = 11,
   localparam int unsigned INFO_W = DEPTH*K*SYM_W
) (
   input  logic [INFO_W-1:0] info_i,
   output logic [INFO_W-1:0] lanes_o
);

   // info symbol (s*DEPTH + d) becomes symbol s of lane d
   for (genvar d = 0; d < DEPTH; d++) begin : g_lane
      for (genvar s = 0; s < K; s++) begin : g_sym
         assign lanes_o[(DEPTH-d)*K*SYM_W-1 - s*SYM_W -: SYM_W] =
                info_i[INFO_W-1 - (s*DEPTH+d)*SYM_W -: SYM_W];
      end
   end

endmodule

// File: rtl/rsf_rs_enc.sv
module rsf_rs_enc
   import rsf_pkg::*;
#(
   parameter int unsigned K    = 11,
   parameter int unsigned NPAR = 4
) (
   input  logic [K*SYM_W-1:0]    msg_i,
   output logic [NPAR*SYM_W-1:0] par_o
);

   if (NPAR > MAX_PAR || NPAR == 0) begin : g_bad_npar
      $error("rsf_rs_enc: NPAR out of range");
   end

   function automatic logic [NPAR*SYM_W-1:0] pack_gen();
      logic [NPAR*SYM_W-1:0] v;
      v = '0;
      for (int i = 0; i < NPAR; i++) v[i*SYM_W +: SYM_W] = gen_coef(NPAR, i);
      return v;
   endfunction

   localparam logic [NPAR*SYM_W-1:0] GEN = pack_gen();

   sym_t rem [NPAR];
   sym_t fb;

   // unrolled division register, one step per message symbol, first symbol first
   always_comb begin
      fb = '0;
      for (int i = 0; i < NPAR; i++) rem[i] = '0;
      for (int k = 0; k < K; k++) begin
         fb = msg_i[(K-k)*SYM_W-1 -: SYM_W] ^ rem[NPAR-1];
         for (int i = NPAR-1; i >= 1; i--)
            rem[i] = rem[i-1] ^ gf_mul(fb, GEN[i*SYM_W +: SYM_W]);
         rem[0] = gf_mul(fb, GEN[0 +: SYM_W]);
      end
      for (int i = 0; i < NPAR; i++) par_o[i*SYM_W +: SYM_W] = rem[i];
   end

endmodule

// File: rtl/rsf_interleave.sv
module rsf_interleave
   import rsf_pkg::*;
#(
   parameter int unsigned DEPTH = 2,
   parameter int unsigned K     = 11,
   parameter int unsigned NPAR  = 4,
   localparam int unsigned N       = K + NPAR,
   localparam int unsigned INFO_W  = DEPTH*K*SYM_W,
   localparam int unsigned PAR_W   = DEPTH*NPAR*SYM_W,
   localparam int unsigned FRAME_W = DEPTH*N*SYM_W
) (
   input  logic [INFO_W-1:0]  lanes_i,
   input  logic [PAR_W-1:0]   par_i,
   output logic [FRAME_W-1:0] frame_o
);

   // frame symbol j takes codeword (j % DEPTH), position (j / DEPTH)
   for (genvar j = 0; j < DEPTH*N; j++) begin : g_slot
      localparam int unsigned D = j % DEPTH;
      localparam int unsigned S = j / DEPTH;
      if (S < K) begin : g_info
         assign frame_o[FRAME_W-1 - j*SYM_W -: SYM_W] =
                lanes_i[(DEPTH-D)*K*SYM_W-1 - S*SYM_W -: SYM_W];
      end else begin : g_par
         assign frame_o[FRAME_W-1 - j*SYM_W -: SYM_W] =
                par_i[(DEPTH-D)*NPAR*SYM_W-1 - (S-K)*SYM_W -: SYM_W];
      end
   end

endmodule

// File: rtl/rsf_frame_enc.sv
module rsf_frame_enc
   import rsf_pkg::*;
#(
   parameter int unsigned DATA_W   = 80,
   parameter int unsigned CTRL_W   = 2,
   parameter int unsigned SLOW_W   = 2,
   parameter int unsigned HDR_W    = 4,
   parameter int unsigned K        = 11,
   parameter int unsigned NPAR     = 4,
   parameter int unsigned DEPTH    = 2,
   parameter logic [HDR_W-1:0] HDR_DATA = 4'b0101,
   parameter logic [HDR_W-1:0] HDR_IDLE = 4'b0110,
   localparam int unsigned N       = K + NPAR,
   localparam int unsigned INFO_W  = HDR_W + CTRL_W + SLOW_W + DATA_W,
   localparam int unsigned PAR_W   = DEPTH*NPAR*SYM_W,
   localparam int unsigned FRAME_W = DEPTH*N*SYM_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DATA_W-1:0]  data_i,
   input  logic [CTRL_W-1:0]  lc_i,
   input  logic [SLOW_W-1:0]  sc_i,
   input  logic               valid_i,
   output logic [FRAME_W-1:0] frame_o
);

   if (INFO_W != DEPTH*K*SYM_W) begin : g_bad_fill
      $error("rsf_frame_enc: payload does not fill the information symbols");
   end
   if (N > (1 << SYM_W) - 1) begin : g_bad_len
      $error("rsf_frame_enc: codeword longer than the field allows");
   end
   if (HDR_DATA == HDR_IDLE) begin : g_bad_hdr
      $error("rsf_frame_enc: header codes must differ");
   end

   logic [HDR_W-1:0]   hdr;
   logic [INFO_W-1:0]  info;
   logic [INFO_W-1:0]  lanes;
   logic [PAR_W-1:0]   par;
   logic [FRAME_W-1:0] frame_d;
   logic [FRAME_W-1:0] frame_q;

   assign hdr  = valid_i ? HDR_DATA : HDR_IDLE;
   assign info = {hdr, lc_i, sc_i, data_i};

   rsf_lane_split #(.DEPTH(DEPTH), .K(K)) u_split (
      .info_i  (info),
      .lanes_o (lanes)
   );

   for (genvar d = 0; d < DEPTH; d++) begin : g_cw
      rsf_rs_enc #(.K(K), .NPAR(NPAR)) u_enc (
         .msg_i (lanes[(DEPTH-d)*K*SYM_W-1 -: K*SYM_W]),
         .par_o (par[(DEPTH-d)*NPAR*SYM_W-1 -: NPAR*SYM_W])
      );
   end

   rsf_interleave #(.DEPTH(DEPTH), .K(K), .NPAR(NPAR)) u_ilv (
      .lanes_i (lanes),
      .par_i   (par),
      .frame_o (frame_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) frame_q <= '0;
      else        frame_q <= frame_d;
   end

   assign frame_o = frame_q;

   // ---------------- assertions ----------------
   logic live_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= 1'b0;
      else        live_q <= 1'b1;
   end

   // syndrome evaluation by Horner's rule on the deinterleaved output
   function automatic logic syn_clean(logic [FRAME_W-1:0] f);
      logic ok;
      sym_t a;
      sym_t s;
      ok = 1'b1;
      for (int d = 0; d < DEPTH; d++) begin
         for (int j = 1; j <= NPAR; j++) begin
            a = sym_t'(1);
            for (int p = 0; p < j; p++) a = xtime(a);
            s = '0;
            for (int i = 0; i < N; i++)
               s = gf_mul(s, a) ^ f[FRAME_W-1 - (i*DEPTH+d)*SYM_W -: SYM_W];
            if (s != '0) ok = 1'b0;
         end
      end
      return ok;
   endfunction

   // R3: header reflects the frame-valid flag of the previous edge
   a_r3_header: assert property (@(posedge clk) disable iff (!rst_n)
      live_q |-> frame_o[FRAME_W-1 -: HDR_W] == ($past(valid_i) ? HDR_DATA : HDR_IDLE));

   // R4: protected payload travels in the clear
   a_r4_payload: assert property (@(posedge clk) disable iff (!rst_n)
      live_q |-> frame_o[FRAME_W-1 -: INFO_W] ==
                 {frame_o[FRAME_W-1 -: HDR_W], $past(lc_i), $past(sc_i), $past(data_i)});

   // R7: both codewords have zero syndromes
   a_r7_syndrome: assert property (@(posedge clk) disable iff (!rst_n)
      live_q |-> syn_clean(frame_o));

   // R8: steady inputs give a steady frame
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      live_q && $stable(data_i) && $stable(lc_i) && $stable(sc_i) && $stable(valid_i)
      |=> $stable(frame_o));

endmodule

// File: tb/rsf_frame_enc_bench.sv
module rsf_frame_enc_bench;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [79:0]  data_i = '0;
   logic [1:0]   lc_i = '0;
   logic [1:0]   sc_i = '0;
   logic         valid_i = 1'b0;
   logic [119:0] frame_o;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   rsf_frame_enc u_rsf_frame_enc (
      .clk(clk), .rst_n(rst_n), .data_i(data_i), .lc_i(lc_i),
      .sc_i(sc_i), .valid_i(valid_i), .frame_o(frame_o)
   );

   // {expected header, valid, lc, sc, data}
   localparam logic [88:0] VEC [8] = '{
      {4'h5, 1'b1, 2'b00, 2'b00, 80'h0},
      {4'h6, 1'b0, 2'b00, 2'b00, 80'h0},
      {4'h5, 1'b1, 2'b11, 2'b11, 80'hFFFF_FFFF_FFFF_FFFF_FFFF},
      {4'h6, 1'b0, 2'b10, 2'b01, 80'h0123_4567_89AB_CDEF_0F1E},
      {4'h5, 1'b1, 2'b01, 2'b10, 80'h8000_0000_0000_0000_0001},
      {4'h6, 1'b0, 2'b11, 2'b00, 80'hA5A5_5A5A_A5A5_5A5A_A5A5},
      {4'h5, 1'b1, 2'b00, 2'b11, 80'hDEAD_BEEF_CAFE_F00D_1234},
      {4'h5, 1'b1, 2'b10, 2'b10, 80'h0000_0000_0000_0000_F000}
   };

   function automatic logic [3:0] bmul(logic [3:0] a, logic [3:0] b);
      logic [3:0] p;
      logic [3:0] x;
      p = '0;
      x = a;
      for (int i = 0; i < 4; i++) begin
         if (b[i]) p = p ^ x;
         x = x[3] ? ((x << 1) ^ 4'h3) : (x << 1);
      end
      return p;
   endfunction

   // reference: long division by g = x^4 + D x^3 + C x^2 + 8 x + 7  (R6), layout per R4/R5
   function automatic logic [119:0] ref_frame(logic v, logic [1:0] lc, logic [1:0] sc,
                                              logic [79:0] d);
      logic [87:0]  info;
      logic [3:0]   cw [2][15];
      logic [3:0]   g [5];
      logic [119:0] f;
      logic [3:0]   c;
      g[0] = 4'h1; g[1] = 4'hD; g[2] = 4'hC; g[3] = 4'h8; g[4] = 4'h7;
      info = {(v ? 4'b0101 : 4'b0110), lc, sc, d};
      for (int k = 0; k < 22; k++) cw[k % 2][k / 2] = info[87-4*k -: 4];
      for (int w = 0; w < 2; w++) begin
         logic [3:0] m [15];
         for (int i = 0; i < 15; i++) m[i] = (i < 11) ? cw[w][i] : 4'h0;
         for (int i = 0; i < 11; i++) begin
            c = m[i];
            for (int t = 1; t <= 4; t++) m[i+t] = m[i+t] ^ bmul(c, g[t]);
         end
         for (int i = 11; i < 15; i++) cw[w][i] = m[i];
      end
      for (int j = 0; j < 30; j++) f[119-4*j -: 4] = cw[j % 2][j / 2];
      return f;
   endfunction

   function automatic bit syn_zero(logic [119:0] f);
      logic [3:0] a;
      logic [3:0] s;
      bit ok;
      ok = 1'b1;
      for (int w = 0; w < 2; w++) begin
         a = 4'h1;
         for (int j = 1; j <= 4; j++) begin
            a = bmul(a, 4'h2);
            s = '0;
            for (int i = 0; i < 15; i++) s = bmul(s, a) ^ f[119-4*(2*i+w) -: 4];
            if (s != 4'h0) ok = 1'b0;
         end
      end
      return ok;
   endfunction

   task automatic chk(string req, logic [119:0] act, logic [119:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(logic v, logic [1:0] lc, logic [1:0] sc, logic [79:0] d);
      valid_i = v; lc_i = lc; sc_i = sc; data_i = d;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL R1 watchdog expired actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [119:0] exp;
      logic [119:0] prev;
      // R2: reset state with nonzero inputs applied
      drive(1'b1, 2'b11, 2'b11, 80'hFFFF_FFFF_FFFF_FFFF_FFFF);
      repeat (3) @(negedge clk);
      chk("R2 reset clears frame", frame_o, 120'h0);
      rst_n = 1'b1;

      // table walk: R3 header, R4 clear payload, R5/R6 full frame, R7 syndromes
      for (int i = 0; i < 8; i++) begin
         drive(VEC[i][84], VEC[i][83:82], VEC[i][81:80], VEC[i][79:0]);
         @(negedge clk);
         exp = ref_frame(VEC[i][84], VEC[i][83:82], VEC[i][81:80], VEC[i][79:0]);
         chk("R3 header code", {116'h0, frame_o[119:116]}, {116'h0, VEC[i][88:85]});
         chk("R4 clear payload", {32'h0, frame_o[119:32]},
             {32'h0, VEC[i][88:85], VEC[i][83:82], VEC[i][81:80], VEC[i][79:0]});
         chk("R5 R6 coded frame", frame_o, exp);
         chk("R7 zero syndromes", {119'h0, syn_zero(frame_o)}, {119'h0, 1'b1});
      end

      // R1: output only moves at the clock edge
      drive(1'b1, 2'b01, 2'b00, 80'h1111_2222_3333_4444_5555);
      @(negedge clk);
      prev = ref_frame(1'b1, 2'b01, 2'b00, 80'h1111_2222_3333_4444_5555);
      chk("R1 captured at edge", frame_o, prev);
      drive(1'b0, 2'b10, 2'b11, 80'h9999_8888_7777_6666_5555);
      #1;
      chk("R1 stable between edges", frame_o, prev);
      @(negedge clk);
      chk("R1 next frame", frame_o, ref_frame(1'b0, 2'b10, 2'b11, 80'h9999_8888_7777_6666_5555));

      // R8: held inputs, frame constant
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R8 held inputs", frame_o, ref_frame(1'b0, 2'b10, 2'b11, 80'h9999_8888_7777_6666_5555));
      end

      // R6/R7 across random payloads
      for (int i = 0; i < 300; i++) begin
         logic [79:0] d;
         logic [3:0]  r;
         d = {$urandom(), $urandom(), $urandom()};
         r = 4'($urandom());
         drive(r[0], r[2:1], {r[3], r[0]}, d);
         @(negedge clk);
         chk("R6 random frame", frame_o, ref_frame(r[0], r[2:1], {r[3], r[0]}, d));
         chk("R7 random syndromes", {119'h0, syn_zero(frame_o)}, {119'h0, 1'b1});
      end

      // R2: asynchronous reset mid-run
      rst_n = 1'b0;
      #1;
      chk("R2 async reset mid-run", frame_o, 120'h0);
      @(negedge clk);
      chk("R2 held in reset", frame_o, 120'h0);
      rst_n = 1'b1;
      drive(1'b1, 2'b00, 2'b01, 80'h0000_0000_0000_0000_0001);
      @(negedge clk);
      chk("R1 after reset release", frame_o, ref_frame(1'b1, 2'b00, 2'b01, 80'h1));

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule